// File: doc/BRIEF.md
# Serial Interrupt Bus Arbitration Unit

This unit competes for ownership of a two-wire, open-drain interrupt bus. Every agent on the bus samples the wires on the rising edge of a shared bus clock. When the message layer reports the bus idle and a message is waiting, the unit starts an arbitration round.

A round has one start cycle followed by one cycle per ID bit. In the start cycle the unit pulls wire 0 low and checks wire 1, which tells it whether another agent has opened an end-of-interrupt transfer on the same edge. In each ID cycle it presents one bit of its arbitration ID, most significant bit first. A 1 bit pulls wire 1 low and a 0 bit releases it, so the wire carries the inverse of the bit and the highest ID survives the wired-AND.

The requester sees the outcome as a one-cycle `grant` or `lost` pulse. After a loss the request stays pending, and the unit tries again once the bus has been busy and has become idle again.

Top module: `sib_arbiter`

## Requirements
- R1: A round starts only on a clock edge where `req` and `bus_idle` are both high.
- R2: During the start cycle, `bus_oe` is 2'b01: wire 0 is pulled low and wire 1 is released. If wire 0 does not read low at the end of that cycle, the attempt is lost.
- R3: If wire 1 reads low at the end of the start cycle, a simultaneous end-of-interrupt start has taken the bus. On the next cycle the unit releases both wires and pulses `lost` for one cycle.
- R4: Each ID cycle releases wire 0. Wire 1 (`bus_oe[1]`) is driven exactly when the current ID bit is 1. The bits go out from bit ID_W-1 down to bit 0, and the two wire enables are never both high.
- R5: If the unit releases wire 1 in an ID cycle and samples it low, it has lost. On the next cycle both enables are 0 and `lost` is high for exactly one cycle.
- R6: Surviving the last ID cycle wins. The next cycle shows a one-cycle `grant` pulse with both wires released and `busy` low. With ID_W=4, grant appears 5 edges after the start edge.
- R7: After `grant` or `lost`, no new round starts until `bus_idle` has been low for at least one edge, even if `req` stays high.
- R8: The ID is captured on the start edge. Changes to `arb_id` later in the round have no effect on that round.
- R9: While `rst` is high, `bus_oe`, `grant`, `lost` and `busy` are all 0.
- R10: `busy` is high from the start edge until the outcome, for at most ID_W+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; wires sampled and enables updated on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | A message is waiting for the bus |
| arb_id | input | ID_W | Arbitration ID of this agent; a higher value has priority |
| bus_idle | input | 1 | Message layer reports that the bus is free |
| bus_in | input | 2 | Current levels of wire 1 and wire 0 (released reads 1) |
| bus_oe | output | 2 | Per-wire enable; when high, that wire is pulled to 0 |
| grant | output | 1 | One-cycle pulse: arbitration won |
| lost | output | 1 | One-cycle pulse: arbitration lost, request still pending |
| busy | output | 1 | A round is in progress |

## Verification
The bench counts rising edges from the start edge (edge 0) and compares every output at the falling edge that follows each rising edge.

- **Start:** the enables show 2'b01 right after edge 0.
- **End-of-interrupt loss:** `lost` appears after edge 1.
- **ID cycles:** the value driven for bit j appears after edge ID_W-j. A loss on bit j appears after edge ID_W-j+1.
- **Win:** the winner's grant appears after edge ID_W+1.

The bench computes each agent's outcome edge before the round, from the set of competing IDs. It then checks all three arbiters on every cycle up to edge 7 and for two cycles after the bus goes busy.

// File: rtl/sib_pkg.sv
package sib_pkg;

  // Wire positions on the two-wire bus
  localparam int WIRE_START = 0;
  localparam int WIRE_ID    = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // waiting for a request and an idle bus
    ST_START = 2'd1,  // start / end-of-interrupt detect cycle
    ST_ID    = 2'd2,  // sending one ID bit per cycle
    ST_HOLD  = 2'd3   // outcome reported, waiting for bus activity
  } sib_state_e;

endpackage

// File: rtl/sib_id_shifter.sv
module sib_id_shifter #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [ID_W-1:0] id_in,
  output logic            cur_bit,
  output logic            last
);

  localparam int CW = $clog2(ID_W + 1);

  logic [ID_W-1:0] shreg;
  logic [CW-1:0]   remaining;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      remaining <= '0;
    end else if (load) begin
      shreg     <= id_in;
      remaining <= CW'(ID_W);
    end else if (shift) begin
      shreg     <= shreg << 1;
      remaining <= remaining - 1'b1;
    end
  end

  assign cur_bit = shreg[ID_W-1];
  assign last    = (remaining == '0);

endmodule

// File: rtl/sib_arb_ctrl.sv
module sib_arb_ctrl
  import sib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       bus_idle,
  input  logic [1:0] bus_in,
  input  logic       cur_bit,
  input  logic       last,
  output logic       load,
  output logic       shift,
  output logic [1:0] bus_oe,
  output logic       grant,
  output logic       lost,
  output logic       busy
);

  sib_state_e st, st_nxt;
  logic [1:0] oe_nxt;
  logic       grant_nxt, lost_nxt, busy_nxt;
  logic       pulled_low;   // wire 1 left released by us but read low
  logic       start_missing;

  assign pulled_low    = !bus_oe[WIRE_ID] && !bus_in[WIRE_ID];
  assign start_missing = bus_in[WIRE_START];

  always_comb begin
    st_nxt    = st;
    oe_nxt    = bus_oe;
    grant_nxt = 1'b0;
    lost_nxt  = 1'b0;
    busy_nxt  = busy;
    load      = 1'b0;
    shift     = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req && bus_idle) begin
          st_nxt   = ST_START;
          oe_nxt   = 2'b01;
          busy_nxt = 1'b1;
          load     = 1'b1;
        end
      end
      ST_START: begin
        if (pulled_low || start_missing) begin
          st_nxt   = ST_HOLD;
          oe_nxt   = 2'b00;
          busy_nxt = 1'b0;
          lost_nxt = 1'b1;
        end else begin
          st_nxt = ST_ID;
          oe_nxt = {cur_bit, 1'b0};
          shift  = 1'b1;
        end
      end
      ST_ID: begin
        if (pulled_low) begin
          st_nxt   = ST_HOLD;
          oe_nxt   = 2'b00;
          busy_nxt = 1'b0;
          lost_nxt = 1'b1;
        end else if (last) begin
          st_nxt    = ST_HOLD;
          oe_nxt    = 2'b00;
          busy_nxt  = 1'b0;
          grant_nxt = 1'b1;
        end else begin
          oe_nxt = {cur_bit, 1'b0};
          shift  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!bus_idle) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bus_oe <= 2'b00;
      grant  <= 1'b0;
      lost   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      st     <= st_nxt;
      bus_oe <= oe_nxt;
      grant  <= grant_nxt;
      lost   <= lost_nxt;
      busy   <= busy_nxt;
    end
  end

endmodule

// File: rtl/sib_arbiter.sv
module sib_arbiter #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic [ID_W-1:0] arb_id,
  input  logic            bus_idle,
  input  logic [1:0]      bus_in,
  output logic [1:0]      bus_oe,
  output logic            grant,
  output logic            lost,
  output logic            busy
);

  logic load, shift, cur_bit, last;

  sib_id_shifter #(.ID_W(ID_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .shift   (shift),
    .id_in   (arb_id),
    .cur_bit (cur_bit),
    .last    (last)
  );

  sib_arb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .bus_idle (bus_idle),
    .bus_in   (bus_in),
    .cur_bit  (cur_bit),
    .last     (last),
    .load     (load),
    .shift    (shift),
    .bus_oe   (bus_oe),
    .grant    (grant),
    .lost     (lost),
    .busy     (busy)
  );

endmodule

// File: rtl/sib_arbiter_chk.sv
module sib_arbiter_chk #(
  parameter int ID_W = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       bus_idle,
  input logic [1:0] bus_in,
  input logic [1:0] bus_oe,
  input logic       grant,
  input logic       lost,
  input logic       busy
);

  logic [7:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else if (!busy) busy_len <= '0;
    else if (busy_len != 8'hFF) busy_len <= busy_len + 1'b1;
  end

  assert_start_gated_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req && bus_idle));

  assert_start_drive_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> bus_oe == 2'b01);

  assert_eoi_loses_R3: assert property (@(posedge clk) disable iff (rst)
    busy && bus_oe[0] && !bus_in[1] |=> lost && !busy);

  assert_one_wire_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_oe));

  assert_released_low_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !bus_oe[1] && !bus_in[1] |=> lost && bus_oe == 2'b00);

  assert_grant_clean_R6: assert property (@(posedge clk) disable iff (rst)
    grant |-> !busy && !lost && bus_oe == 2'b00);

  assert_no_quick_retry_R7: assert property (@(posedge clk) disable iff (rst)
    (lost || grant) && bus_idle |=> !busy);

  assert_round_length_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_len < 8'(ID_W + 1));

endmodule

bind sib_arbiter sib_arbiter_chk #(.ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .bus_idle (bus_idle),
  .bus_in   (bus_in),
  .bus_oe   (bus_oe),
  .grant    (grant),
  .lost     (lost),
  .busy     (busy)
);

// File: tb/test_sib_arbiter.sv
`timescale 1ns/1ps
module test_sib_arbiter;
  localparam int ID_W = 4;
  localparam int NA   = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                      rst;
  logic [NA-1:0]             req;
  logic [NA-1:0][ID_W-1:0]   ids;
  logic                      bus_idle;
  logic [1:0]                inj;   // bench-driven pull-downs (EOI injector)
  logic [1:0]                bus;
  logic [NA-1:0][1:0]        oe;
  logic [NA-1:0]             grant, lost, busy;

  int n_chk  = 0;
  int n_fail = 0;

  always_comb begin
    bus = 2'b11;
    for (int a = 0; a < NA; a++) bus = bus & ~oe[a];
    bus = bus & ~inj;
  end

  for (genvar g = 0; g < NA; g++) begin : g_agent
    sib_arbiter #(.ID_W(ID_W)) i_sib_arbiter (
      .clk      (clk),
      .rst      (rst),
      .req      (req[g]),
      .arb_id   (ids[g]),
      .bus_idle (bus_idle),
      .bus_in   (bus),
      .bus_oe   (oe[g]),
      .grant    (grant[g]),
      .lost     (lost[g]),
      .busy     (busy[g])
    );
  end

  task automatic chk(input string tag, input string what, input int a,
                     input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s agent %0d %s: actual %0d expected %0d", tag, a, what, act, exp);
    end
  endtask

  task automatic chk_agent(input int a, input string tag, input bit eb,
                           input bit eg, input bit el, input logic [1:0] eo);
    chk(tag, "busy",   a, int'(busy[a]),  int'(eb));
    chk(tag, "grant",  a, int'(grant[a]), int'(eg));
    chk(tag, "lost",   a, int'(lost[a]),  int'(el));
    chk(tag, "bus_oe", a, int'(oe[a]),    int'(eo));
  endtask

  task automatic idle_all(input string tag);
    for (int a = 0; a < NA; a++) chk_agent(a, tag, 1'b0, 1'b0, 1'b0, 2'b00);
  endtask

  int                      end_k [NA];
  bit                      won   [NA];
  logic [NA-1:0][ID_W-1:0] snap;

  // Predict each agent's outcome edge, then compare every cycle.
  task automatic run_round(input bit eoi, input bit chg, input string tag);
    logic [NA-1:0] alive;
    bit            any1;
    snap  = ids;
    alive = req;
    for (int a = 0; a < NA; a++) begin
      end_k[a] = -1;
      won[a]   = 1'b0;
    end
    if (eoi) begin
      for (int a = 0; a < NA; a++) if (alive[a]) end_k[a] = 1;
    end else begin
      for (int j = ID_W - 1; j >= 0; j--) begin
        any1 = 1'b0;
        for (int a = 0; a < NA; a++) if (alive[a] && snap[a][j]) any1 = 1'b1;
        for (int a = 0; a < NA; a++)
          if (alive[a] && !snap[a][j] && any1) begin
            end_k[a] = ID_W - j + 1;
            alive[a] = 1'b0;
          end
      end
      for (int a = 0; a < NA; a++)
        if (alive[a]) begin
          end_k[a] = ID_W + 1;
          won[a]   = 1'b1;
        end
    end
    inj      = eoi ? 2'b11 : 2'b00;
    bus_idle = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      for (int a = 0; a < NA; a++) begin
        if (end_k[a] < 0)
          chk_agent(a, {tag, " R1"}, 1'b0, 1'b0, 1'b0, 2'b00);
        else if (k < end_k[a])
          chk_agent(a, (k == 0) ? {tag, " R2"} : {tag, " R4 R10"}, 1'b1, 1'b0, 1'b0,
                    (k == 0) ? 2'b01 : {snap[a][ID_W-k], 1'b0});
        else if (k == end_k[a])
          chk_agent(a, won[a] ? {tag, " R6"} : (eoi ? {tag, " R3"} : {tag, " R5"}),
                    1'b0, won[a], !won[a], 2'b00);
        else
          chk_agent(a, {tag, " R7"}, 1'b0, 1'b0, 1'b0, 2'b00);
      end
      if (k == 1) begin
        inj = 2'b00;
        if (chg) ids = ~ids;   // R8: late ID change must be ignored
      end
    end
    bus_idle = 1'b0;
    for (int a = 0; a < NA; a++) if (won[a]) req[a] = 1'b0;
    repeat (2) begin
      @(negedge clk);
      idle_all("R7");
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst      = 1'b1;
    req      = '1;
    bus_idle = 1'b1;
    inj      = 2'b00;
    ids      = '0;
    repeat (3) @(negedge clk);
    idle_all("R9");
    req = '0;
    rst = 1'b0;
    @(negedge clk);

    // R1: request without an idle bus never starts
    req      = '1;
    bus_idle = 1'b0;
    repeat (4) begin
      @(negedge clk);
      idle_all("R1");
    end

    // three-way contest, then retries of the losers
    ids[0] = 4'd5; ids[1] = 4'd12; ids[2] = 4'd9;
    run_round(1'b0, 1'b0, "R4 R5 R6");   // 12 wins
    run_round(1'b0, 1'b0, "R5 R6 R7");   // 9 wins
    run_round(1'b0, 1'b0, "R6 R7");      // 5 wins

    // simultaneous end-of-interrupt beats everyone
    ids[0] = 4'd15; ids[1] = 4'd3; ids[2] = 4'd7;
    req    = '1;
    run_round(1'b1, 1'b0, "R3");
    run_round(1'b0, 1'b1, "R8");         // 15 wins despite late change
    run_round(1'b0, 1'b0, "R5 R6");      // changed ids 12 vs 8
    run_round(1'b0, 1'b0, "R6");

    // lowest ID alone: wire 1 never driven
    ids[0] = '0;
    req    = 3'b001;
    run_round(1'b0, 1'b0, "R4 R6");

    summary();
    $finish;
  end

endmodule